// File: doc/BRIEF.md
# Byte-Addressed Memory Target on a Two-Wire Serial Bus

This block is the bus-side front end of a small nonvolatile byte store. The store is modelled as a register array plus a timer that stands in for the programming time. The block watches a two-wire serial bus (clock and open-drain data). It recognises bus start and stop events and decodes a 7-bit device address with a direction bit. It then takes two word-address bytes and one data byte for a write, or sends one data byte for a read. It acknowledges each accepted byte by pulling the data line low during the ninth clock.

A write is committed only when the master ends the transaction with a stop after a full data byte and its acknowledge. The block then starts a write cycle. For the length of that cycle it ignores the bus completely, so a master that keeps addressing the device sees no acknowledge until the store is ready again. Words inside a protected window, given by a low and a high word address on input ports, still acknowledge every byte. Their data is dropped and no write cycle starts. A read returns the word at an internal pointer. The pointer resets to zero and advances by one after each read. A write loads it with the written address plus one.

Top module: `nvm_bus_target`

## Requirements
- R1: A device byte whose upper 7 bits equal `DEV_ADDR` is acknowledged (data held low during the ninth clock). In a write (bit 0 = 0), both word-address bytes (high byte first, the word is the low `AW` bits of the 16-bit value) and the data byte are acknowledged too.
- R2: A stop after the data byte and its acknowledge stores the data byte at the addressed word, and a later read of that word returns it.
- R3: A stop in the middle of the data byte, or before any data byte, stores nothing, starts no write cycle, and leaves the pointer unchanged.
- R4: While a write cycle runs, the block never pulls the data line low, and a device byte that follows a start is not acknowledged.
- R5: Once the write cycle has ended, a start plus a matching device byte is acknowledged again.
- R6: The write cycle lasts `WR_CYCLES` system clocks from the detected stop.
- R7: A write to a word `w` with `prot_lo <= w <= prot_hi` is acknowledged at every byte. It changes no word, moves no pointer and starts no write cycle, so a following device byte is acknowledged at once. When `prot_lo > prot_hi`, nothing is protected.
- R8: Reset sets the pointer to word 0 and leaves the array contents alone. A read advances the pointer by one, wrapping modulo 2^`AW`. A committed write sets it to the written word plus one.
- R9: A read (device byte bit 0 = 1) sends the 8 bits of the word at the pointer, most significant bit first, one bit per clock, changing the data line only while the clock is low.
- R10: After the master's not-acknowledge and stop that end a read, the data line is released and the next start plus device byte is acknowledged.
- R11: A device byte with a different address is not acknowledged. Further bytes are then ignored, with no acknowledge, until the next start.
- R12: A start is the data line falling while the clock is high, and a stop is the data line rising while the clock is high. A start inside an unfinished write abandons it and begins a new device byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| prot_lo | input | AW | Lowest protected word address |
| prot_hi | input | AW | Highest protected word address |
| sda_oe | output | 1 | Pull bus data low when 1, release when 0 |

## Verification
Every word of a 16-word array is written twice with two different arithmetic value patterns. The first pass has protection disabled. The second pass has a three-word window, so a read-back sweep through the wrapping pointer separates committed words from dropped ones word by word. The write cycle is probed with two address attempts placed just before and just after its computed end. This separates a correct cycle length from a short or long one. Truncated writes (stop mid-byte, stop after the word address), a foreign device address followed by a bare byte, a repeated start and a reset mid-run each leave a distinct trace in the pointer or in the data read back.

// File: rtl/nvm_bus_pkg.sv
package nvm_bus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK, ST_ALO, ST_ALO_ACK,
    ST_DAT, ST_DAT_ACK, ST_HOLD, ST_RD, ST_RD_ACK
  } bus_state_t;
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else if (g == 0) begin
          scl_q[g] <= scl_i;
          sda_q[g] <= sda_i;
        end else begin
          scl_q[g] <= scl_q[g-1];
          sda_q[g] <= sda_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/nvm_word_array.sv
module nvm_word_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/prog_busy_timer.sv
module prog_busy_timer #(
  parameter int WR_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);
  localparam int TW = $clog2(WR_CYCLES + 1);
  logic [TW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)            left <= '0;
    else if (go)        left <= TW'(WR_CYCLES);
    else if (left != 0) left <= left - 1'b1;
  end

  assign busy = (left != 0);

  // R4
  go_when_idle_chk: assert property (@(posedge clk) disable iff (rst) go |-> !busy);
  // R6
  busy_after_go_chk: assert property (@(posedge clk) disable iff (rst) go |=> busy);
endmodule

// File: rtl/nvm_bus_target.sv
module nvm_bus_target
  import nvm_bus_pkg::*;
#(
  parameter int           AW        = 8,
  parameter logic [6:0]   DEV_ADDR  = 7'h50,
  parameter int           WR_CYCLES = 500000,
  parameter int           SYNC_STG  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [AW-1:0] prot_lo,
  input  logic [AW-1:0] prot_hi,
  output logic          sda_oe
);
  localparam int DW = 8;
  localparam int CW = 4;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, wr_go, prot_hit, rw;
  bus_state_t state;
  logic [CW-1:0] bitn;
  logic [DW-1:0] sh, ahi, alo, wdat, txb, rdata;
  logic [AW-1:0] ptr, waddr;
  logic [15:0] addr16;

  bus_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign addr16   = {ahi, alo};
  assign waddr    = addr16[AW-1:0];
  assign prot_hit = (waddr >= prot_lo) && (waddr <= prot_hi);
  assign wr_go    = !busy && stop_det && (state == ST_HOLD) && !prot_hit;

  nvm_word_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(wr_go), .waddr(waddr), .wdata(wdat),
    .raddr(ptr), .rdata(rdata)
  );

  prog_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .go(wr_go), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      bitn   <= '0;
      sh     <= '0;
      ahi    <= '0;
      alo    <= '0;
      wdat   <= '0;
      txb    <= '0;
      rw     <= 1'b0;
      ptr    <= '0;
    end else if (busy) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      bitn   <= '0;
    end else if (start_det) begin
      state  <= ST_DEV;
      sda_oe <= 1'b0;
      bitn   <= '0;
    end else if (stop_det) begin
      if (wr_go) ptr <= waddr + 1'b1;
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      bitn   <= '0;
    end else begin
      unique case (state)
        ST_DEV, ST_AHI, ST_ALO, ST_DAT: begin
          if (scl_rise) begin
            sh   <= {sh[DW-2:0], sda_s};
            bitn <= bitn + 1'b1;
          end else if (scl_fall && bitn == CW'(8)) begin
            bitn <= '0;
            case (state)
              ST_DEV: begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_DEV_ACK;
                end else begin
                  state  <= ST_IDLE;
                end
              end
              ST_AHI: begin ahi  <= sh; sda_oe <= 1'b1; state <= ST_AHI_ACK; end
              ST_ALO: begin alo  <= sh; sda_oe <= 1'b1; state <= ST_ALO_ACK; end
              default: begin wdat <= sh; sda_oe <= 1'b1; state <= ST_DAT_ACK; end
            endcase
          end
        end
        ST_DEV_ACK: if (scl_fall) begin
          if (rw) begin
            txb    <= rdata;
            sda_oe <= ~rdata[DW-1];
            bitn   <= '0;
            state  <= ST_RD;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_AHI;
          end
        end
        ST_AHI_ACK: if (scl_fall) begin sda_oe <= 1'b0; state <= ST_ALO;  end
        ST_ALO_ACK: if (scl_fall) begin sda_oe <= 1'b0; state <= ST_DAT;  end
        ST_DAT_ACK: if (scl_fall) begin sda_oe <= 1'b0; state <= ST_HOLD; end
        ST_RD: if (scl_fall) begin
          if (bitn == CW'(7)) begin
            sda_oe <= 1'b0;
            ptr    <= ptr + 1'b1;
            state  <= ST_RD_ACK;
          end else begin
            txb    <= {txb[DW-2:0], 1'b0};
            sda_oe <= ~txb[DW-2];
            bitn   <= bitn + 1'b1;
          end
        end
        ST_RD_ACK: if (scl_rise) state <= ST_IDLE;
        default: ;
      endcase
    end
  end

  // R4
  quiet_when_busy_chk: assert property (@(posedge clk) disable iff (rst) busy |-> !sda_oe);
  // R9
  change_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  // R1
  bit_count_chk: assert property (@(posedge clk) disable iff (rst) bitn <= CW'(8));
  // R10
  release_on_stop_chk: assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_oe);
endmodule

// File: tb/sim_nvm_bus_target.sv
module sim_nvm_bus_target;
  localparam int AW = 4;
  localparam int WRC = 400;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [AW-1:0] prot_lo = '1, prot_hi = '0;
  logic sda_oe;
  wire sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  int cyc = 0;
  int t_stop = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvm_bus_target #(.AW(AW), .DEV_ADDR(7'h50), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .prot_lo(prot_lo), .prot_hi(prot_hi), .sda_oe(sda_oe)
  );

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bstart();
    sda_m = 1'b1; w(H); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0;
  endtask

  task automatic bstop();
    w(2); sda_m = 1'b0; w(H); scl_m = 1'b1; w(H); sda_m = 1'b1; t_stop = cyc; w(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      w(2); sda_m = b[i]; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    w(2); sda_m = 1'b1; w(H); scl_m = 1'b1; w(H/2);
    ack = (sda_line == 1'b0);
    w(H/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit lowhi_ok);
    lowhi_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H); scl_m = 1'b1; w(H/2); b[i] = sda_line;
      w(1); if (sda_line != b[i]) lowhi_ok = 1'b0;
      w(H/2 - 1); scl_m = 1'b0;
    end
    w(2); sda_m = 1'b1; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0; w(2);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, output bit all_ack);
    bit k0, k1, k2, k3;
    bstart(); send_byte(8'hA0, k0); send_byte(8'h00, k1);
    send_byte(8'(a), k2); send_byte(d, k3); bstop();
    all_ack = k0 & k1 & k2 & k3;
  endtask

  task automatic probe(output bit ack);
    bstart(); send_byte(8'hA0, ack); bstop();
  endtask

  task automatic wait_ready();
    bit k;
    for (int n = 0; n < 20; n++) begin
      probe(k);
      if (k) break;
    end
  endtask

  task automatic do_read(output logic [7:0] d, output bit ack, output bit stable);
    bstart(); send_byte(8'hA1, ack); recv_byte(d, stable); bstop();
  endtask

  function automatic logic [7:0] pat_g(input int a); return 8'((a * 29 + 3) & 8'hFF); endfunction
  function automatic logic [7:0] pat_f(input int a); return 8'((a * 53 + 8'h91) & 8'hFF); endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit k, st;
    logic [7:0] d;
    w(5); rst = 1'b0; w(2);
    chk(sda_oe == 1'b0, "R8 reset sda released", sda_oe, 0);

    // fill pass, nothing protected (lo > hi)
    for (int a = 0; a < 16; a++) begin
      do_write(AW'(a), pat_g(a), k);
      chk(k, "R1 write bytes acked", k, 1);
      if (a == 0) begin
        probe(k);
        chk(!k, "R4 no ack while writing", k, 0);
      end
      wait_ready();
    end

    // R6 cycle length: probe just before and just after the computed end
    do_write(AW'(3), pat_g(3), k);
    while (cyc < t_stop + WRC - 40) w(1);
    probe(k);
    chk(!k, "R6 still busy before end", k, 0);
    wait_ready();
    do_write(AW'(3), pat_g(3), k);
    while (cyc < t_stop + WRC + 20) w(1);
    probe(k);
    chk(k, "R5 R6 ack after cycle end", k, 1);

    // protected pass
    prot_lo = AW'(10); prot_hi = AW'(12);
    for (int a = 0; a < 16; a++) begin
      do_write(AW'(a), pat_f(a), k);
      chk(k, "R7 R1 acks in protected pass", k, 1);
      if (a >= 10 && a <= 12) begin
        probe(k);
        chk(k, "R7 no write cycle for protected word", k, 1);
      end else begin
        wait_ready();
      end
    end

    // pointer wrapped to 0 after word 15
    for (int a = 0; a < 16; a++) begin
      logic [7:0] e;
      e = (a >= 10 && a <= 12) ? pat_g(a) : pat_f(a);
      do_read(d, k, st);
      chk(k, "R1 read address acked", k, 1);
      chk(d == e, "R2 R7 R8 R9 read back", d, e);
      chk(st, "R9 data stable while clock high", st, 1);
    end
    chk(sda_oe == 1'b0, "R10 released after read", sda_oe, 0);
    probe(k);
    chk(k, "R10 next address acked", k, 1);

    // R3: stop mid data byte at word 2
    bstart(); send_byte(8'hA0, k); send_byte(8'h00, k); send_byte(8'h02, k);
    send_bits(8'hEE, 4); bstop();
    probe(k);
    chk(k, "R3 no cycle after mid-byte stop", k, 1);
    // R3: stop right after word address 5
    bstart(); send_byte(8'hA0, k); send_byte(8'h00, k); send_byte(8'h05, k); bstop();
    probe(k);
    chk(k, "R3 no cycle after address-only stop", k, 1);
    for (int a = 0; a < 4; a++) begin
      do_read(d, k, st);
      chk(d == pat_f(a), "R3 R8 pointer and data untouched", d, pat_f(a));
    end

    // R11 foreign address then a bare matching byte
    bstart(); send_byte(8'hA6, k);
    chk(!k, "R11 foreign address nacked", k, 0);
    send_byte(8'hA0, k);
    chk(!k, "R11 byte without start ignored", k, 0);
    bstop();
    probe(k);
    chk(k, "R11 acked after new start", k, 1);

    // R12 repeated start abandons a write to word 7, read word 4
    bstart(); send_byte(8'hA0, k); send_byte(8'h00, k); send_byte(8'h07, k);
    bstart(); send_byte(8'hA1, k);
    chk(k, "R12 repeated start address acked", k, 1);
    recv_byte(d, st); bstop();
    chk(d == pat_f(4), "R12 read after repeated start", d, pat_f(4));
    probe(k);
    chk(k, "R12 abandoned write started no cycle", k, 1);

    // R8 reset returns pointer to 0, array kept
    w(2); rst = 1'b1; w(3); rst = 1'b0; w(3);
    do_read(d, k, st);
    chk(d == pat_f(0), "R8 pointer zero after reset", d, pat_f(0));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule